// File: doc/BRIEF.md
# Configurable Clock Distribution Network

This block picks the clocks that reach the registers of a small programmable-logic fabric. It takes four dedicated clock pins and one clock made inside the fabric by a designated clock logic block. It drives three clock lines for the logic blocks and two clock lines for the I/O cells. Line 0 of the logic-block group is wired straight to pin 0, the reference clock. Each of the other four lines has its own static source select.

The pins have different reach. Pin 1 may feed only logic-block lines. Pin 3 may feed only I/O-cell lines. Pin 2 and the internal clock may feed lines of either group. Every selectable line uses the same 3-bit source code: 0 = pin 0, 1 = pin 1, 2 = pin 2, 3 = pin 3, 4 = internal clock, and 5 to 7 reserved. A code that names a source the line may not use holds that line low. It also raises a configuration error flag.

Selects are captured only on configuration-clock edges at which the synchronous active-high fabric reset is high, so a clock never switches while the fabric runs. While the reset is applied, every selectable line is held low. The lines come alive on the first configuration-clock edge that samples the reset low.

Top module: `clk_dist_net`

## Requirements
- R1: `lb_clk[0]` equals `y_pin[0]` at all times, during reset as well.
- R2: For logic-block lines 1 and 2, code 1 gives `y_pin[1]`, code 2 gives `y_pin[2]` and code 4 gives `int_clk`. The code for line 1 is `lb_sel[2:0]` and the code for line 2 is `lb_sel[5:3]`.
- R3: For I/O-cell lines 0 and 1, code 2 gives `y_pin[2]`, code 3 gives `y_pin[3]` and code 4 gives `int_clk`. The code for line 0 is `io_sel[2:0]` and the code for line 1 is `io_sel[5:3]`.
- R4: A logic-block line whose code is 0, 3, 5, 6 or 7 stays low whatever the pins and the internal clock do.
- R5: An I/O-cell line whose code is 0, 1, 5, 6 or 7 stays low whatever the pins and the internal clock do.
- R6: After a configuration-clock edge with `rst` high, `cfg_err` is 1 if any of the four captured codes is not allowed on its line, and 0 otherwise. The flag holds its value while `rst` stays low.
- R7: Codes are captured only on configuration-clock edges with `rst` high. Changing `lb_sel` or `io_sel` while `rst` is low has no effect on any output.
- R8: From a configuration-clock edge that samples `rst` high until the next edge that samples it low, `lb_clk[2:1]` and `io_clk` are 0. After that edge they follow their captured selects.
- R9: Each selectable line decodes its own code, so the four lines may carry four different sources at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; captures selects and samples the reset |
| rst | input | 1 | Synchronous active-high fabric reset; selects load while it is high |
| y_pin | input | 4 | Dedicated clock pins 0 to 3 |
| int_clk | input | 1 | Clock made by the designated clock logic block |
| lb_sel | input | 6 | Source codes for logic-block lines 1 and 2, 3 bits each |
| io_sel | input | 6 | Source codes for I/O-cell lines 0 and 1, 3 bits each |
| lb_clk | output | 3 | Logic-block clock lines; bit 0 is the reference |
| io_clk | output | 2 | I/O-cell clock lines |
| cfg_err | output | 1 | Set when the captured configuration holds a disallowed route |

## Verification
The bench builds the block with its default counts of three logic-block lines and two I/O-cell lines. That is four selectable lines of a 3-bit code, small enough for a rotating table to place every one of the eight codes on every line, both the legal and the illegal ones. For each configuration, each source is driven high alone, so each line shows exactly which source it passes, and cross-wiring between lines or pins becomes visible. Directed cases then cover the reset gating edge, select changes during run and the persistence of the error flag.

// File: rtl/clk_dist_pkg.sv
package clk_dist_pkg;

    localparam int NUM_PINS = 4;
    localparam int SRC_W    = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_PIN0 = 3'd0,
        SRC_PIN1 = 3'd1,
        SRC_PIN2 = 3'd2,
        SRC_PIN3 = 3'd3,
        SRC_INT  = 3'd4,
        SRC_RSV5 = 3'd5,
        SRC_RSV6 = 3'd6,
        SRC_RSV7 = 3'd7
    } src_e;

    typedef enum logic {
        LINE_LOGIC = 1'b0,
        LINE_IO    = 1'b1
    } line_e;

    typedef struct packed {
        logic [NUM_PINS-1:0] pin;
        logic                internal;
    } clk_src_t;

    function automatic logic src_allowed(input line_e kind, input logic [SRC_W-1:0] code);
        logic ok;
        ok = 1'b0;
        case (src_e'(code))
            SRC_PIN1: ok = (kind == LINE_LOGIC);
            SRC_PIN2: ok = 1'b1;
            SRC_PIN3: ok = (kind == LINE_IO);
            SRC_INT:  ok = 1'b1;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/clk_dist_cfg_reg.sv
module clk_dist_cfg_reg
    import clk_dist_pkg::*;
#(
    parameter int NUM_LB_SEL = 2,
    parameter int NUM_IO     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LB_SEL*SRC_W-1:0] lb_sel_in,
    input  logic [NUM_IO*SRC_W-1:0]     io_sel_in,
    output logic [NUM_LB_SEL*SRC_W-1:0] lb_sel_q,
    output logic [NUM_IO*SRC_W-1:0]     io_sel_q,
    output logic                        run_q,
    output logic                        cfg_err
);

    logic [NUM_LB_SEL-1:0] lb_bad;
    logic [NUM_IO-1:0]     io_bad;

    for (genvar i = 0; i < NUM_LB_SEL; i++) begin : g_lb_chk
        assign lb_bad[i] = !src_allowed(LINE_LOGIC, lb_sel_in[i*SRC_W +: SRC_W]);
    end

    for (genvar j = 0; j < NUM_IO; j++) begin : g_io_chk
        assign io_bad[j] = !src_allowed(LINE_IO, io_sel_in[j*SRC_W +: SRC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_sel_q <= lb_sel_in;
            io_sel_q <= io_sel_in;
            cfg_err  <= (|lb_bad) | (|io_bad);
            run_q    <= 1'b0;
        end else begin
            run_q    <= 1'b1;
        end
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(lb_sel_q) && $stable(io_sel_q)));  // R7

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_err));  // R6

endmodule

// File: rtl/clk_dist_line_mux.sv
module clk_dist_line_mux
    import clk_dist_pkg::*;
#(
    parameter line_e KIND = LINE_LOGIC
) (
    input  clk_src_t         src,
    input  logic [SRC_W-1:0] sel,
    input  logic             en,
    output logic             clk_o
);

    logic picked;

    if (KIND == LINE_LOGIC) begin : g_logic
        always_comb begin
            case (src_e'(sel))
                SRC_PIN1: picked = src.pin[1];
                SRC_PIN2: picked = src.pin[2];
                SRC_INT:  picked = src.internal;
                default:  picked = 1'b0;
            endcase
        end
    end else begin : g_io
        always_comb begin
            case (src_e'(sel))
                SRC_PIN2: picked = src.pin[2];
                SRC_PIN3: picked = src.pin[3];
                SRC_INT:  picked = src.internal;
                default:  picked = 1'b0;
            endcase
        end
    end

    assign clk_o = en & picked;

endmodule

// File: rtl/clk_dist_net.sv
module clk_dist_net
    import clk_dist_pkg::*;
#(
    parameter int NUM_LB = 3,
    parameter int NUM_IO = 2
) (
    input  logic                        cfg_clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         y_pin,
    input  logic                        int_clk,
    input  logic [(NUM_LB-1)*SRC_W-1:0] lb_sel,
    input  logic [NUM_IO*SRC_W-1:0]     io_sel,
    output logic [NUM_LB-1:0]           lb_clk,
    output logic [NUM_IO-1:0]           io_clk,
    output logic                        cfg_err
);

    localparam int NUM_LB_SEL = NUM_LB - 1;

    logic [NUM_LB_SEL*SRC_W-1:0] lb_sel_q;
    logic [NUM_IO*SRC_W-1:0]     io_sel_q;
    logic                        run_q;
    clk_src_t                    src;

    assign src.pin      = y_pin;
    assign src.internal = int_clk;

    clk_dist_cfg_reg #(
        .NUM_LB_SEL (NUM_LB_SEL),
        .NUM_IO     (NUM_IO)
    ) u_cfg (
        .clk       (cfg_clk),
        .rst       (rst),
        .lb_sel_in (lb_sel),
        .io_sel_in (io_sel),
        .lb_sel_q  (lb_sel_q),
        .io_sel_q  (io_sel_q),
        .run_q     (run_q),
        .cfg_err   (cfg_err)
    );

    assign lb_clk[0] = y_pin[0];

    for (genvar i = 0; i < NUM_LB_SEL; i++) begin : g_lb_line
        clk_dist_line_mux #(.KIND(LINE_LOGIC)) u_mux (
            .src   (src),
            .sel   (lb_sel_q[i*SRC_W +: SRC_W]),
            .en    (run_q),
            .clk_o (lb_clk[i+1])
        );

        AST_LB_ILLEGAL_LOW: assert property (@(posedge cfg_clk) disable iff (rst)
            !src_allowed(LINE_LOGIC, lb_sel_q[i*SRC_W +: SRC_W]) |-> !lb_clk[i+1]);  // R4
    end

    for (genvar j = 0; j < NUM_IO; j++) begin : g_io_line
        clk_dist_line_mux #(.KIND(LINE_IO)) u_mux (
            .src   (src),
            .sel   (io_sel_q[j*SRC_W +: SRC_W]),
            .en    (run_q),
            .clk_o (io_clk[j])
        );

        AST_IO_ILLEGAL_LOW: assert property (@(posedge cfg_clk) disable iff (rst)
            !src_allowed(LINE_IO, io_sel_q[j*SRC_W +: SRC_W]) |-> !io_clk[j]);  // R5
    end

    AST_GATED_IN_RESET: assert property (@(posedge cfg_clk) disable iff (rst)
        !run_q |-> (lb_clk[NUM_LB-1:1] == '0 && io_clk == '0));  // R8

    AST_ERR_FLAGS_BAD_ROUTE: assert property (@(posedge cfg_clk) disable iff (rst)
        (!src_allowed(LINE_LOGIC, lb_sel_q[SRC_W-1:0]) ||
         !src_allowed(LINE_IO, io_sel_q[SRC_W-1:0])) |-> cfg_err);  // R6

endmodule

// File: tb/tb_clk_dist_net.sv
module tb_clk_dist_net;

    logic       cfg_clk = 1'b0;
    logic       rst     = 1'b1;
    logic [3:0] y_pin   = 4'b0000;
    logic       int_clk = 1'b0;
    logic [5:0] lb_sel  = 6'd0;
    logic [5:0] io_sel  = 6'd0;
    logic [2:0] lb_clk;
    logic [1:0] io_clk;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;

    always #4 cfg_clk = ~cfg_clk;

    clk_dist_net dut (
        .cfg_clk (cfg_clk),
        .rst     (rst),
        .y_pin   (y_pin),
        .int_clk (int_clk),
        .lb_sel  (lb_sel),
        .io_sel  (io_sel),
        .lb_clk  (lb_clk),
        .io_clk  (io_clk),
        .cfg_err (cfg_err)
    );

    // entry: {expected error, lb line1, lb line2, io line0, io line1}
    localparam logic [12:0] VEC [14] = '{
        {1'b1, 3'd0, 3'd1, 3'd2, 3'd3},
        {1'b0, 3'd1, 3'd2, 3'd3, 3'd4},
        {1'b1, 3'd2, 3'd3, 3'd4, 3'd5},
        {1'b1, 3'd3, 3'd4, 3'd5, 3'd6},
        {1'b1, 3'd4, 3'd5, 3'd6, 3'd7},
        {1'b1, 3'd5, 3'd6, 3'd7, 3'd0},
        {1'b1, 3'd6, 3'd7, 3'd0, 3'd1},
        {1'b1, 3'd7, 3'd0, 3'd1, 3'd2},
        {1'b0, 3'd2, 3'd4, 3'd4, 3'd2},
        {1'b0, 3'd4, 3'd1, 3'd2, 3'd3},
        {1'b0, 3'd1, 3'd1, 3'd2, 3'd2},
        {1'b0, 3'd4, 3'd4, 3'd4, 3'd4},
        {1'b1, 3'd2, 3'd2, 3'd1, 3'd3},
        {1'b1, 3'd1, 3'd2, 3'd0, 3'd4}
    };

    function automatic logic ref_lb(input logic [2:0] c, input logic [3:0] y, input logic ic);
        case (c)
            3'd1:    return y[1];
            3'd2:    return y[2];
            3'd4:    return ic;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ref_io(input logic [2:0] c, input logic [3:0] y, input logic ic);
        case (c)
            3'd2:    return y[2];
            3'd3:    return y[3];
            3'd4:    return ic;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [2:0] l1, input logic [2:0] l2,
                            input logic [2:0] i0, input logic [2:0] i1);
        @(negedge cfg_clk);
        lb_sel = {l2, l1};
        io_sel = {i1, i0};
        rst    = 1'b1;
        @(negedge cfg_clk);
        rst    = 1'b0;
        @(negedge cfg_clk);
    endtask

    function automatic logic [4:0] expect_out(input logic [2:0] l1, input logic [2:0] l2,
                                              input logic [2:0] i0, input logic [2:0] i1,
                                              input logic [3:0] y, input logic ic);
        return {ref_lb(l2, y, ic), ref_lb(l1, y, ic), y[0], ref_io(i1, y, ic), ref_io(i0, y, ic)};
    endfunction

    task automatic sweep_sources(input string req, input logic [2:0] l1, input logic [2:0] l2,
                                 input logic [2:0] i0, input logic [2:0] i1);
        for (int p = 0; p < 5; p++) begin
            y_pin   = (p < 4) ? (4'b0001 << p) : 4'b0000;
            int_clk = (p == 4);
            #1;
            chk(req, {lb_clk, io_clk}, expect_out(l1, l2, i0, i1, y_pin, int_clk));
        end
        y_pin   = 4'b0000;
        int_clk = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state: R8 gating, R1 reference pass-through
        lb_sel = {3'd2, 3'd1};
        io_sel = {3'd3, 3'd2};
        repeat (2) @(negedge cfg_clk);
        y_pin   = 4'b1111;
        int_clk = 1'b1;
        #1;
        chk("R8 lines low in reset", {lb_clk[2:1], io_clk}, 4'b0000);
        chk("R1 ref in reset high", lb_clk[0], 1'b1);
        y_pin[0] = 1'b0;
        #1;
        chk("R1 ref in reset low", lb_clk[0], 1'b0);
        y_pin[0] = 1'b1;
        @(negedge cfg_clk);
        rst = 1'b0;
        #1;
        chk("R8 still low before release edge", {lb_clk[2:1], io_clk}, 4'b0000);
        @(negedge cfg_clk);
        chk("R8 live after release edge", {lb_clk, io_clk}, 5'b11111);
        chk("R6 legal config no error", cfg_err, 1'b0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 14; i++) begin
            logic [2:0] l1, l2, i0, i1;
            l1 = VEC[i][11:9];
            l2 = VEC[i][8:6];
            i0 = VEC[i][5:3];
            i1 = VEC[i][2:0];
            load_cfg(l1, l2, i0, i1);
            chk("R6 error flag", cfg_err, VEC[i][12]);
            sweep_sources("R2 R3 R4 R5 R9 routing", l1, l2, i0, i1);
        end

        // R7: select changes during run are ignored
        load_cfg(3'd1, 3'd4, 3'd3, 3'd2);
        lb_sel = {3'd3, 3'd0};
        io_sel = {3'd1, 3'd7};
        repeat (3) @(negedge cfg_clk);
        sweep_sources("R7 run-time select ignored", 3'd1, 3'd4, 3'd3, 3'd2);
        chk("R7 error unaffected in run", cfg_err, 1'b0);

        // R6: error persists through run when inputs become legal
        load_cfg(3'd3, 3'd1, 3'd2, 3'd2);
        lb_sel = {3'd1, 3'd1};
        repeat (4) @(negedge cfg_clk);
        chk("R6 error held during run", cfg_err, 1'b1);
        sweep_sources("R4 illegal line stays low", 3'd3, 3'd1, 3'd2, 3'd2);

        // R1 during run
        y_pin[0] = 1'b1;
        #1;
        chk("R1 ref in run", lb_clk[0], 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule